// File: doc/BRIEF.md
# Priority Reference Selector with Revertive Control

The block chooses one working reference from a set of candidate input clocks. Each candidate has a programmable priority number and a validity flag from outside qualification logic. The lowest non-zero priority number wins. A priority of zero removes a candidate from consideration. When two candidates have the same priority, the one with the lower index wins. Every cycle the block reports two things: the best valid candidate, and the reference actually selected.

A control bit chooses between two switching policies. In revertive operation the selection moves at once to any valid candidate with a strictly better priority. In non-revertive operation the better candidate appears only in the top-candidate report, and the selection stays where it is. The selection is left in either mode when the selected input loses validity or is disabled.

A strap input marks the device as master (high) or slave (low). In slave mode the block always switches revertively, whatever value was written to the control bit. Readback of that bit shows 1, while the written value is kept for later. Slave mode also forces one designated input to priority 1.

Top module: `ref_priority_sel`

## Requirements
- R1: After reset, the outputs read as follows:
  - `sel_o` = 0, `top_o` = 0, `top_vld_o` = 0 and `no_ref_o` = 1.
  - The stored revertive bit is 0 (non-revertive).
  - Every priority entry i holds i+1.
- R2: A smaller non-zero priority number has precedence. An input with priority 0 is never reported as top and never selected.
- R3: Among valid enabled inputs of equal priority, the lower index is the top candidate.
- R4: `top_o` and `top_vld_o` show the best valid enabled input one clock after the inputs and table that produced it. While no input qualifies, `top_vld_o` is 0 and `top_o` holds its last value.
- R5: With revertive behaviour in force, a valid input with a strictly smaller priority number than the selected one becomes `sel_o` one clock later. An input of equal priority does not cause a switch.
- R6: With non-revertive behaviour, a better input only updates `top_o` one clock later. `sel_o` stays unchanged while the selected input remains valid and enabled.
- R7: If the selected input becomes invalid or gets priority 0, `sel_o` moves to the best valid enabled input one clock later, in either mode.
- R8: When no input is valid and enabled, `no_ref_o` is 1 one clock later and `sel_o` keeps its last value.
- R9: `ctrl_rdata_o[0]` reads the stored revertive bit when `master_i` = 1, and reads 1 when `master_i` = 0.
  - With `master_i` = 0 the block switches revertively.
  - A write made while in slave mode is stored and becomes visible when the strap returns high.
- R10: While `master_i` = 0, input `SLAVE_IDX` (default 7) is treated as priority 1, whatever its programmed value. Its programmed value applies again once `master_i` = 1.
- R11: `ctrl_rdata_o[1]` mirrors `master_i` combinationally. Writes cannot change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | N_IN | Per-input validity flags |
| prio_wr_i | input | 1 | Priority table write strobe |
| prio_idx_i | input | IW | Input index to write |
| prio_data_i | input | PW | Priority value written (0 = disabled) |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_revert_i | input | 1 | Revertive bit value written |
| master_i | input | 1 | Master (1) / slave (0) strap |
| ctrl_rdata_o | output | 2 | Control readback: bit1 strap, bit0 effective revertive bit |
| sel_o | output | IW | Selected reference index |
| top_o | output | IW | Best valid enabled input index |
| top_vld_o | output | 1 | top_o refers to a qualifying input |
| no_ref_o | output | 1 | No qualifying input exists |

## Verification
The following results are due one clock after the validity vector, table and strap that produce them:
- `sel_o`, `top_o`, `top_vld_o` and `no_ref_o`;
- a priority or control write, which lands on one edge and moves the selection on the next, so it takes two clocks to reach `sel_o`.

The readback word is combinational and is due in the same cycle as the strap.

The bench drives inputs on the falling edge and samples on the next falling edge. Its behavioural model advances on each rising edge from the inputs held at that edge, so every comparison lines up with the register stage that produces it.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SW_HOLD,
    SW_LOST,
    SW_REVERT,
    SW_NONE
  } sw_cause_e;
endpackage

// File: rtl/refsel_prio_tab.sv
module refsel_prio_tab #(
  parameter int N_IN      = 8,
  parameter int PW        = 4,
  parameter int IW        = 3,
  parameter int SLAVE_IDX = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [PW-1:0]            data_i,
  input  logic                     slave_i,
  output logic [N_IN-1:0][PW-1:0]  eff_prio_o
);
  for (genvar g = 0; g < N_IN; g++) begin : g_ent
    logic [PW-1:0] prio_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      prio_q <= PW'(g + 1);
      else if (wr_i && idx_i == IW'(g)) prio_q <= data_i;
    end
    if (g == SLAVE_IDX) begin : g_forced
      assign eff_prio_o[g] = slave_i ? PW'(1) : prio_q;
    end else begin : g_plain
      assign eff_prio_o[g] = prio_q;
    end
  end
endmodule

// File: rtl/refsel_best.sv
module refsel_best #(
  parameter int N_IN = 8,
  parameter int PW   = 4,
  parameter int IW   = 3
) (
  input  logic [N_IN-1:0]          valid_i,
  input  logic [N_IN-1:0][PW-1:0]  prio_i,
  output logic                     best_vld_o,
  output logic [IW-1:0]            best_idx_o,
  output logic [PW-1:0]            best_prio_o
);
  // strict compare keeps the lower index on a tie
  always_comb begin
    best_vld_o  = 1'b0;
    best_idx_o  = '0;
    best_prio_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (valid_i[i] && prio_i[i] != '0 && (!best_vld_o || prio_i[i] < best_prio_o)) begin
        best_vld_o  = 1'b1;
        best_idx_o  = IW'(i);
        best_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/refsel_sel_ctrl.sv
module refsel_sel_ctrl
  import refsel_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int PW   = 4,
  parameter int IW   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IN-1:0]          valid_i,
  input  logic [N_IN-1:0][PW-1:0]  eff_prio_i,
  input  logic                     revert_i,
  input  logic                     best_vld_i,
  input  logic [IW-1:0]            best_idx_i,
  input  logic [PW-1:0]            best_prio_i,
  output logic [IW-1:0]            sel_o,
  output logic [IW-1:0]            top_o,
  output logic                     top_vld_o,
  output logic                     no_ref_o
);
  logic [IW-1:0] sel_q, top_q;
  logic          sel_vld_q, top_vld_q;
  logic          cur_ok;
  sw_cause_e     cause;

  assign cur_ok = sel_vld_q && valid_i[sel_q] && eff_prio_i[sel_q] != '0;

  always_comb begin
    if (!best_vld_i)                                        cause = SW_NONE;
    else if (!cur_ok)                                       cause = SW_LOST;
    else if (revert_i && best_prio_i < eff_prio_i[sel_q])   cause = SW_REVERT;
    else                                                    cause = SW_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      sel_vld_q <= 1'b0;
      top_q     <= '0;
      top_vld_q <= 1'b0;
    end else begin
      unique case (cause)
        SW_NONE:            sel_vld_q <= 1'b0;
        SW_LOST, SW_REVERT: begin
          sel_q     <= best_idx_i;
          sel_vld_q <= 1'b1;
        end
        default:            sel_vld_q <= 1'b1;
      endcase
      if (best_vld_i) top_q <= best_idx_i;
      top_vld_q <= best_vld_i;
    end
  end

  assign sel_o     = sel_q;
  assign top_o     = top_q;
  assign top_vld_o = top_vld_q;
  assign no_ref_o  = !sel_vld_q;
endmodule

// File: rtl/ref_priority_sel.sv
module ref_priority_sel #(
  parameter int N_IN      = 8,
  parameter int PW        = 4,
  parameter int SLAVE_IDX = 7,
  localparam int IW       = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  valid_i,
  input  logic             prio_wr_i,
  input  logic [IW-1:0]    prio_idx_i,
  input  logic [PW-1:0]    prio_data_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_revert_i,
  input  logic             master_i,
  output logic [1:0]       ctrl_rdata_o,
  output logic [IW-1:0]    sel_o,
  output logic [IW-1:0]    top_o,
  output logic             top_vld_o,
  output logic             no_ref_o
);
  logic                     revert_q, revert_eff;
  logic [N_IN-1:0][PW-1:0]  eff_prio;
  logic                     best_vld;
  logic [IW-1:0]            best_idx;
  logic [PW-1:0]            best_prio;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        revert_q <= 1'b0;
    else if (ctrl_wr_i) revert_q <= ctrl_revert_i;
  end

  // slave strap forces revertive; stored bit stays hidden
  assign revert_eff   = revert_q | ~master_i;
  assign ctrl_rdata_o = {master_i, revert_eff};

  refsel_prio_tab #(.N_IN(N_IN), .PW(PW), .IW(IW), .SLAVE_IDX(SLAVE_IDX)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (prio_wr_i),
    .idx_i      (prio_idx_i),
    .data_i     (prio_data_i),
    .slave_i    (~master_i),
    .eff_prio_o (eff_prio)
  );

  refsel_best #(.N_IN(N_IN), .PW(PW), .IW(IW)) u_best (
    .valid_i     (valid_i),
    .prio_i      (eff_prio),
    .best_vld_o  (best_vld),
    .best_idx_o  (best_idx),
    .best_prio_o (best_prio)
  );

  refsel_sel_ctrl #(.N_IN(N_IN), .PW(PW), .IW(IW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .eff_prio_i  (eff_prio),
    .revert_i    (revert_eff),
    .best_vld_i  (best_vld),
    .best_idx_i  (best_idx),
    .best_prio_i (best_prio),
    .sel_o       (sel_o),
    .top_o       (top_o),
    .top_vld_o   (top_vld_o),
    .no_ref_o    (no_ref_o)
  );
endmodule

// File: rtl/ref_priority_sel_chk.sv
module ref_priority_sel_chk #(
  parameter int N_IN = 8,
  parameter int IW   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] valid_i,
  input logic            prio_wr_i,
  input logic            master_i,
  input logic [1:0]      ctrl_rdata_o,
  input logic [IW-1:0]   sel_o,
  input logic [IW-1:0]   top_o,
  input logic            top_vld_o,
  input logic            no_ref_o
);
  logic [N_IN-1:0] vprev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vprev <= '0;
    else         vprev <= valid_i;
  end

  a_r4_top_was_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld_o |-> vprev[top_o]);

  a_r7_sel_was_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !no_ref_o |-> vprev[sel_o]);

  a_r8_noref_holds_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_ref_o |-> $stable(sel_o));

  a_r6_nonrevert_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_ref_o && valid_i[sel_o] && !ctrl_rdata_o[0] && master_i
     && $past(master_i) && !$past(prio_wr_i)) |=> $stable(sel_o));
endmodule

bind ref_priority_sel ref_priority_sel_chk #(.N_IN(N_IN), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .prio_wr_i    (prio_wr_i),
  .master_i     (master_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .sel_o        (sel_o),
  .top_o        (top_o),
  .top_vld_o    (top_vld_o),
  .no_ref_o     (no_ref_o)
);

// File: tb/tb_ref_priority_sel.sv
`timescale 1ns/1ps
module tb_ref_priority_sel;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = 3;
  localparam int SL = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  valid = '0;
  logic          prio_wr = 1'b0;
  logic [IW-1:0] prio_idx = '0;
  logic [PW-1:0] prio_data = '0;
  logic          ctrl_wr = 1'b0;
  logic          ctrl_rev = 1'b0;
  logic          master = 1'b1;
  logic [1:0]    rdata;
  logic [IW-1:0] sel, top;
  logic          top_vld, no_ref;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ref_priority_sel #(.N_IN(N), .PW(PW), .SLAVE_IDX(SL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .prio_wr_i(prio_wr), .prio_idx_i(prio_idx), .prio_data_i(prio_data),
    .ctrl_wr_i(ctrl_wr), .ctrl_revert_i(ctrl_rev), .master_i(master),
    .ctrl_rdata_o(rdata), .sel_o(sel), .top_o(top),
    .top_vld_o(top_vld), .no_ref_o(no_ref)
  );

  // behavioural reference model
  int m_prio [N];
  int m_rev, m_sel, m_top, m_topv, m_noref, m_selv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_prio[i] = i + 1;
      m_rev = 0; m_sel = 0; m_top = 0; m_topv = 0; m_noref = 1; m_selv = 0;
    end else begin
      int ep [N];
      int bv, bi, bp, rev, ok;
      for (int i = 0; i < N; i++) ep[i] = (!master && i == SL) ? 1 : m_prio[i];
      bv = 0; bi = 0; bp = 0;
      for (int i = 0; i < N; i++)
        if (valid[i] && ep[i] != 0 && (bv == 0 || ep[i] < bp)) begin
          bv = 1; bi = i; bp = ep[i];
        end
      rev = (m_rev != 0 || !master) ? 1 : 0;
      if (bv == 0) begin
        m_noref = 1; m_selv = 0;
      end else begin
        ok = (m_selv != 0 && valid[m_sel] && ep[m_sel] != 0) ? 1 : 0;
        if (ok == 0 || (rev != 0 && bp < ep[m_sel])) m_sel = bi;
        m_selv = 1; m_noref = 0;
        m_top = bi;
      end
      m_topv = bv;
      if (prio_wr) m_prio[prio_idx] = prio_data;
      if (ctrl_wr) m_rev = ctrl_rev;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare to model every cycle, away from the rising edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(sel) == m_sel, "R5 model sel", int'(sel), m_sel);
    chk(int'(top) == m_top, "R4 model top", int'(top), m_top);
    chk(int'(top_vld) == m_topv, "R4 model top_vld", int'(top_vld), m_topv);
    chk(int'(no_ref) == m_noref, "R8 model no_ref", int'(no_ref), m_noref);
    chk(int'(rdata) == ((master ? 2 : 0) + ((m_rev != 0 || !master) ? 1 : 0)),
        "R9 model readback", int'(rdata), (master ? 2 : 0) + ((m_rev != 0 || !master) ? 1 : 0));
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prio(input int idx, input int val);
    prio_wr = 1'b1; prio_idx = IW'(idx); prio_data = PW'(val);
    tick();
    prio_wr = 1'b0;
  endtask

  task automatic wr_rev(input bit v);
    ctrl_wr = 1'b1; ctrl_rev = v;
    tick();
    ctrl_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state, R11 strap mirror
    chk(sel == 0, "R1 sel", sel, 0);
    chk(no_ref == 1, "R1 no_ref", no_ref, 1);
    chk(top_vld == 0, "R1 top_vld", top_vld, 0);
    chk(rdata == 2'b10, "R1 R11 readback", rdata, 2);

    valid = 8'b0000_0100; tick();
    chk(sel == 2 && no_ref == 0, "R7 first pick", sel, 2);
    chk(top == 2 && top_vld, "R4 top", top, 2);

    // R6 non-revertive: better input only reported
    valid = 8'b0000_0101; tick();
    chk(top == 0, "R6 top moves", top, 0);
    chk(sel == 2, "R6 sel held", sel, 2);
    tick(3);
    chk(sel == 2, "R6 sel still held", sel, 2);

    // enable revertive: switch after write lands
    wr_rev(1'b1);
    chk(rdata[0] == 1, "R9 revert readback", rdata[0], 1);
    tick();
    chk(sel == 0, "R5 revert switch", sel, 0);

    // R7 selected lost
    valid = 8'b0000_0100; tick();
    chk(sel == 2, "R7 lost switch", sel, 2);

    // R5 newly valid better input
    valid = 8'b0000_0110; tick();
    chk(sel == 1, "R5 newly valid", sel, 1);

    // R2 disable via priority 0
    wr_prio(1, 0); tick();
    chk(sel == 2, "R2 disabled leaves", sel, 2);
    chk(top == 2, "R2 top skips disabled", top, 2);

    // R3 tie to lower index, R5 no switch on equal priority
    wr_prio(5, 3); valid = 8'b0010_0100; tick();
    chk(top == 2, "R3 tie lower index", top, 2);
    wr_prio(1, 3); valid = 8'b0010_0110; tick();
    chk(top == 1, "R3 tie new lower index", top, 1);
    chk(sel == 2, "R5 equal prio no switch", sel, 2);

    // R8 no reference
    valid = '0; tick();
    chk(no_ref == 1, "R8 no_ref", no_ref, 1);
    chk(sel == 2, "R8 sel held", sel, 2);
    chk(top_vld == 0, "R4 top_vld low", top_vld, 0);
    tick(2);
    chk(sel == 2, "R8 sel still held", sel, 2);

    // slave mode
    wr_rev(1'b0);
    chk(rdata == 2'b10, "R9 master readback 0", rdata, 2);
    master = 1'b0; #1;
    chk(rdata == 2'b01, "R9 R11 slave readback", rdata, 1);
    valid = 8'b0000_0100; tick();
    chk(sel == 2, "R7 slave pick", sel, 2);
    valid = 8'b1000_0100; tick();
    chk(top == 7, "R10 forced prio", top, 7);
    chk(sel == 7, "R9 slave revertive", sel, 7);
    wr_rev(1'b0);
    chk(rdata[0] == 1, "R9 slave write hidden", rdata[0], 1);
    master = 1'b1; #1;
    chk(rdata == 2'b10, "R9 stored value visible", rdata, 2);
    tick();
    chk(top == 2, "R10 forcing released", top, 2);
    chk(sel == 7, "R6 sel kept after strap", sel, 7);

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule